// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits beside a two-port memory and watches the left and right access ports. Each port brings an active-low enable, a read/write strobe (low for a write) and an address. When both ports are enabled on the same address, the block picks one port to go ahead and drives an active-low busy flag to the other port. The flagged port's write is suppressed before it reaches the array, so a collision never corrupts a word. The memory array itself is not part of the block.

Ports are ranked by arrival, one clock edge at a time. A port whose enable and address were already in place on the previous edge has arrived earlier than a port that has just shown up. If both show up on the same edge, the left port is preferred. The winner is recorded in an ownership register and kept until the collision ends. This stops the grant from flipping while the two accesses overlap.

A mode input switches between two behaviours. In master mode the block arbitrates and drives busy. In slave mode it does no arbitration, its busy outputs stay high, and a busy input per port serves only to inhibit that port's writes. This lets several instances share one arbitration decision.

Top module: `dp_busy_arbiter`

## Requirements
- R1: In master mode, with reset low, both busy outputs are high (1 = not busy) whenever either enable is high (1 = port idle) or the two addresses differ.
- R2: In master mode, with reset low, while both enables are low and the addresses are equal, exactly one busy output is low.
- R3: The write output of a port is low (1 = no write; 0 = write reaches memory) only when that port's enable is low, its read/write strobe is low, and the port is not blocked. In master mode a port is blocked exactly when its own busy output is low.
- R4: At the start of a collision in master mode, a port counts as having arrived earlier if on the previous clock edge it was already enabled on the same address. If only one port arrived earlier, that port wins and the other port's busy goes low.
- R5: At the start of a collision where neither port arrived earlier, or both did, busy goes low on exactly one side. The design picks the left port as the winner.
- R6: While a collision continues without a break, busy stays on the same port it was first given to, even if the arrival rule would now choose the other port.
- R7: A loser's busy returns high in the same cycle that the collision ends, that is, when an address changes or either enable goes high.
- R8: In slave mode both busy outputs are high and no arbitration is done. A low busy input blocks its own port's writes, and a high busy input lets them through.
- R9: In master mode the busy inputs have no effect on the write outputs.
- R10: While the synchronous reset is high, both busy outputs are high. Reset also clears the ownership and arrival history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| masterMode | input | 1 | 1 = arbitrate and drive busy, 0 = busy inputs only inhibit writes |
| leftCeN | input | 1 | Left enable, active low |
| leftRwN | input | 1 | Left read/write strobe, 0 = write |
| leftAddr | input | ADDR_W | Left address |
| rightCeN | input | 1 | Right enable, active low |
| rightRwN | input | 1 | Right read/write strobe, 0 = write |
| rightAddr | input | ADDR_W | Right address |
| leftBusyIn | input | 1 | Left write inhibit in slave mode, active low |
| rightBusyIn | input | 1 | Right write inhibit in slave mode, active low |
| leftBusyN | output | 1 | Left busy flag, active low |
| rightBusyN | output | 1 | Right busy flag, active low |
| leftWeN | output | 1 | Gated left write to memory, active low |
| rightWeN | output | 1 | Gated right write to memory, active low |

## Verification
The bench builds the block with ADDR_W = 4 and draws random addresses from only four values. Collisions are therefore frequent. Some accesses are held over several cycles, so earlier arrivals on one side, simultaneous arrivals and long overlapping collisions all occur many times. The same address comparator is exercised as at the default width of 15. Directed cases cover the ownership hold where the arrival rule alone would pick the other port, the release cycle, reset in the middle of a collision, and slave mode.

// File: rtl/dpba_pkg.sv
package dpba_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Strobes from control to datapath: a set flag means that side lost.
  typedef struct packed {
    logic flagLeft;
    logic flagRight;
  } busy_strobes_t;
endpackage

// File: rtl/dpba_datapath.sv
module dpba_datapath
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              masterMode,
  input  logic              leftCeN,
  input  logic              leftRwN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightCeN,
  input  logic              rightRwN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              leftBusyIn,
  input  logic              rightBusyIn,
  input  busy_strobes_t     strobes,
  output logic              matchNow,
  output logic              leftHeld,
  output logic              rightHeld,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWeN,
  output logic              rightWeN
);
  localparam int SIDES = 2;

  logic [SIDES-1:0]             sideEn;
  logic [SIDES-1:0][ADDR_W-1:0] sideAddr;
  logic [SIDES-1:0]             sideHeld;

  assign sideEn   = {~rightCeN, ~leftCeN};
  assign sideAddr = {rightAddr, leftAddr};

  // One arrival tracker per port: a port is "held" when it was already
  // enabled on the same address at the previous edge.
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic              prevEn;
    logic [ADDR_W-1:0] prevAddr;
    always_ff @(posedge clk) begin
      if (rst) begin
        prevEn <= 1'b0;
      end else begin
        prevEn <= sideEn[s];
      end
      prevAddr <= sideAddr[s];
    end
    assign sideHeld[s] = sideEn[s] && prevEn && (prevAddr == sideAddr[s]);
  end

  assign matchNow  = sideEn[0] && sideEn[1] && (leftAddr == rightAddr);
  assign leftHeld  = sideHeld[0];
  assign rightHeld = sideHeld[1];

  logic leftBlocked, rightBlocked;
  always_comb begin
    leftBusyN    = ~(masterMode & strobes.flagLeft);
    rightBusyN   = ~(masterMode & strobes.flagRight);
    leftBlocked  = masterMode ? strobes.flagLeft  : ~leftBusyIn;
    rightBlocked = masterMode ? strobes.flagRight : ~rightBusyIn;
    leftWeN      = leftCeN  | leftRwN  | leftBlocked;
    rightWeN     = rightCeN | rightRwN | rightBlocked;
  end

  a_r1_quiet_without_match: assert property (@(posedge clk) disable iff (rst)
    (masterMode && (leftCeN || rightCeN || leftAddr != rightAddr))
      |-> (leftBusyN && rightBusyN));

  a_r2_single_loser: assert property (@(posedge clk) disable iff (rst)
    (masterMode && !leftCeN && !rightCeN && leftAddr == rightAddr)
      |-> ($countones({~leftBusyN, ~rightBusyN}) == 1));

  a_r3_loser_write_gated: assert property (@(posedge clk) disable iff (rst)
    (!leftBusyN |-> leftWeN) and (!rightBusyN |-> rightWeN));

  a_r8_slave_inhibit: assert property (@(posedge clk) disable iff (rst)
    !masterMode |-> (leftBusyN && rightBusyN
                     && (!leftBusyIn -> leftWeN) && (!rightBusyIn -> rightWeN)));
endmodule

// File: rtl/dpba_control.sv
module dpba_control
  import dpba_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          masterMode,
  input  logic          matchNow,
  input  logic          leftHeld,
  input  logic          rightHeld,
  output busy_strobes_t strobes
);
  owner_e ownQ, winner;

  always_comb begin
    winner = OWN_NONE;
    if (!rst && masterMode && matchNow) begin
      if (ownQ != OWN_NONE)          winner = ownQ;
      else if (rightHeld && !leftHeld) winner = OWN_RIGHT;
      else                           winner = OWN_LEFT;  // left first or tie
    end
    strobes.flagLeft  = (winner == OWN_RIGHT);
    strobes.flagRight = (winner == OWN_LEFT);
  end

  always_ff @(posedge clk) begin
    if (rst) ownQ <= OWN_NONE;
    else     ownQ <= winner;
  end

  a_r6_owner_kept: assert property (@(posedge clk) disable iff (rst)
    (masterMode && matchNow && ownQ == OWN_RIGHT) |-> strobes.flagLeft && !strobes.flagRight);

  a_r6_owner_kept_left: assert property (@(posedge clk) disable iff (rst)
    (masterMode && matchNow && ownQ == OWN_LEFT) |-> strobes.flagRight && !strobes.flagLeft);
endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              masterMode,
  input  logic              leftCeN,
  input  logic              leftRwN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightCeN,
  input  logic              rightRwN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              leftBusyIn,
  input  logic              rightBusyIn,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWeN,
  output logic              rightWeN
);
  busy_strobes_t strobes;
  logic matchNow, leftHeld, rightHeld;

  dpba_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk(clk), .rst(rst), .masterMode(masterMode),
    .leftCeN(leftCeN), .leftRwN(leftRwN), .leftAddr(leftAddr),
    .rightCeN(rightCeN), .rightRwN(rightRwN), .rightAddr(rightAddr),
    .leftBusyIn(leftBusyIn), .rightBusyIn(rightBusyIn), .strobes(strobes),
    .matchNow(matchNow), .leftHeld(leftHeld), .rightHeld(rightHeld),
    .leftBusyN(leftBusyN), .rightBusyN(rightBusyN),
    .leftWeN(leftWeN), .rightWeN(rightWeN)
  );

  dpba_control u_control (
    .clk(clk), .rst(rst), .masterMode(masterMode),
    .matchNow(matchNow), .leftHeld(leftHeld), .rightHeld(rightHeld),
    .strobes(strobes)
  );
endmodule

// File: tb/dp_busy_arbiter_bench.sv
module dp_busy_arbiter_bench;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic masterMode = 1'b1;
  logic lCe = 1'b1, lRw = 1'b1, rCe = 1'b1, rRw = 1'b1;
  logic [AW-1:0] lA = '0, rA = '0;
  logic lBi = 1'b1, rBi = 1'b1;
  logic lBusy, rBusy, lWe, rWe;

  int errors = 0;
  int checks = 0;
  string tagOverride = "";

  // bench model state: 0 none, 1 left owns, 2 right owns
  int mOwn = 0;
  bit mPrevL = 0, mPrevR = 0;
  logic [AW-1:0] mPrevLA = '0, mPrevRA = '0;
  int nextOwn = 0;

  always #2 clk = ~clk;  // 250 MHz

  dp_busy_arbiter #(.ADDR_W(AW)) u_dp_busy_arbiter (
    .clk(clk), .rst(rst), .masterMode(masterMode),
    .leftCeN(lCe), .leftRwN(lRw), .leftAddr(lA),
    .rightCeN(rCe), .rightRwN(rRw), .rightAddr(rA),
    .leftBusyIn(lBi), .rightBusyIn(rBi),
    .leftBusyN(lBusy), .rightBusyN(rBusy), .leftWeN(lWe), .rightWeN(rWe)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit expWe(input logic ce, input logic rw, input bit blk);
    return ce | rw | blk;
  endfunction

  // Inputs were set at the falling edge; check, then let the rising edge pass.
  task automatic step();
    bit m, lH, rH, tie, lBlk, rBlk;
    int win;
    string tag, weTag;
    #1;
    m  = !lCe && !rCe && (lA == rA);
    lH = mPrevL && !lCe && (mPrevLA == lA);
    rH = mPrevR && !rCe && (mPrevRA == rA);
    tie = 0;
    if (rst)              begin win = 0; tag = "R10"; end
    else if (!masterMode) begin win = 0; tag = "R8"; end
    else if (!m)          begin win = 0; tag = "R1"; end
    else if (mOwn != 0)   begin win = mOwn; tag = "R6"; end
    else if (lH && !rH)   begin win = 1; tag = "R4"; end
    else if (rH && !lH)   begin win = 2; tag = "R4"; end
    else                  begin win = 3; tie = 1; tag = "R5"; end
    if (tagOverride != "") tag = tagOverride;
    if (tie) begin
      chk((lBusy ^ rBusy) == 1'b1, tag, "one busy on tie", {lBusy, rBusy}, 1);
      win = !rBusy ? 1 : 2;  // either side accepted
    end else begin
      chk(lBusy == !(win == 2), tag, "left busy", lBusy, !(win == 2));
      chk(rBusy == !(win == 1), tag, "right busy", rBusy, !(win == 1));
    end
    lBlk = masterMode ? (win == 2) : !lBi;
    rBlk = masterMode ? (win == 1) : !rBi;
    weTag = (tagOverride != "") ? tagOverride : (masterMode ? "R3" : "R8");
    chk(lWe == expWe(lCe, lRw, lBlk), weTag, "left write", lWe, expWe(lCe, lRw, lBlk));
    chk(rWe == expWe(rCe, rRw, rBlk), weTag, "right write", rWe, expWe(rCe, rRw, rBlk));
    nextOwn = (m && masterMode && !rst) ? win : 0;
    @(posedge clk);
    mOwn = nextOwn;
    mPrevL = !rst && !lCe;
    mPrevR = !rst && !rCe;
    mPrevLA = lA;
    mPrevRA = rA;
    @(negedge clk);
  endtask

  task automatic setPorts(input logic lc, input logic lr, input int la,
                          input logic rc, input logic rr, input int ra);
    lCe = lc; lRw = lr; lA = AW'(la);
    rCe = rc; rRw = rr; rA = AW'(ra);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10: reset held with a collision present
    setPorts(0, 0, 5, 0, 0, 5);
    step(); step();
    rst = 1'b0;
    // R1: idle ports, then different addresses
    setPorts(1, 0, 5, 1, 0, 5); step();
    setPorts(0, 0, 5, 0, 0, 6); step();
    // R4: left arrives first, right joins writing; R3 right write blocked
    setPorts(0, 1, 9, 1, 1, 0); step();
    setPorts(0, 0, 9, 0, 0, 9); step();
    step(); step();  // R6 both held, left keeps it
    // R7: left moves away, busy released at once
    tagOverride = "R7";
    setPorts(0, 0, 10, 0, 0, 9); step();
    tagOverride = "";
    // R4 right first, then R6: both held but right keeps ownership
    setPorts(0, 0, 2, 0, 0, 3); step();
    setPorts(0, 0, 3, 0, 0, 3); step();
    step(); step();
    // R7: right enable rises
    tagOverride = "R7";
    setPorts(0, 0, 3, 1, 0, 3); step();
    tagOverride = "";
    // R5: simultaneous arrival from idle
    setPorts(1, 1, 0, 1, 1, 0); step();
    setPorts(0, 0, 7, 0, 0, 7); step(); step();
    // R9: busy inputs low in master mode do nothing
    tagOverride = "R9";
    lBi = 0; rBi = 0;
    setPorts(0, 0, 1, 0, 0, 2); step();
    tagOverride = "";
    // R8: slave mode with a collision
    masterMode = 0;
    setPorts(0, 0, 4, 0, 0, 4); step();
    lBi = 1; step();
    rBi = 1; lBi = 0; step();
    // R10 mid-collision reset
    masterMode = 1; lBi = 1; rBi = 1;
    setPorts(0, 0, 8, 1, 0, 8); step();
    setPorts(0, 0, 8, 0, 0, 8); step();
    rst = 1; step(); rst = 0; step(); step();
    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 1) == 0) begin
        lCe = ($urandom_range(0, 3) == 0); lRw = $urandom_range(0, 1); lA = AW'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 1) == 0) begin
        rCe = ($urandom_range(0, 3) == 0); rRw = $urandom_range(0, 1); rA = AW'($urandom_range(0, 3));
      end
      lBi = ($urandom_range(0, 2) != 0);
      rBi = ($urandom_range(0, 2) != 0);
      masterMode = ($urandom_range(0, 9) != 0);
      rst = ($urandom_range(0, 199) == 0);
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule